// File: doc/BRIEF.md
# DMX512 Addressed Slot Capture

This block sits behind a UART byte receiver on a DMX512 lighting line. The receiver and a separate break detector hand it a break pulse, a byte strobe with its data, and a framing-error flag. From each frame that opens with the expected start code, the block picks out four consecutive slots beginning at a configurable base address. It presents them as four channel bytes that always change together, with a single new-data pulse per completed capture.

Three mode inputs shape the result. A ganged mode copies the first addressed slot to all four channels. An in-band configuration mode treats a captured set whose first byte is 0x81 as a configuration frame and issues the other three bytes on a write strobe in place of updating the channels. A per-channel on/off-only mask limits a channel to full off or full on: any value in between leaves that channel as it was.

Top module: `dmx_slot_capture`

## Requirements
- R1: After a break, the first byte is the start code; unless it is free of framing error and equal to `start_code_i`, the rest of the frame is ignored.
- R2: Data bytes after the start code are counted from 1 in a 16-bit slot counter; capture starts on the byte whose count equals `base_i` exactly.
- R3: A framing error on the start code or any data byte before the capture completes aborts the frame; nothing is output until the next break.
- R4: The first addressed slot raises `seen_o` for one cycle, in the cycle after the edge that takes that byte.
- R5: With `gang_i` high, the first addressed slot completes the capture with its value on all four channels; the configuration check is skipped in this mode.
- R6: With `gang_i` low, the three bytes after the first addressed slot fill channels 2, 3 and 4 in order; `chan_o[7:0]` is channel 1 and `chan_o[31:24]` channel 4. Later slots are ignored until the next break.
- R7: With `cfg_mode_i` high and `gang_i` low, a completed set whose channel-1 byte is 0x81 pulses `cfg_we_o` for one cycle with `cfg_o = {ch4, ch3, ch2}` (channel 2 in `cfg_o[7:0]`); channels and `new_o` stay unchanged. Any other first byte leaves every output unchanged.
- R8: For channel i with `onoff_i[i]` high, a captured value other than 0x00 or 0xFF is dropped and the channel keeps its previous value.
- R9: Each completed non-configuration capture pulses `new_o` once, and all four channels update in that same cycle, one cycle after the edge that takes the last byte; otherwise `chan_o` holds.
- R10: Only base addresses 1 to 509 are served; for 0 or 510 to 511 no slot is captured and `seen_o` stays low.
- R11: A break during a capture restarts the slot count and discards the partial set.
- R12: Bytes after a completed capture or an aborted frame are ignored until a break; a break and a byte in the same cycle act as a break only.
- R13: During and just after reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brk_i | input | 1 | One-cycle pulse: break detected |
| byte_vld_i | input | 1 | One-cycle strobe: byte_i holds a received byte |
| byte_i | input | 8 | Received byte |
| frm_err_i | input | 1 | Framing error on the byte of this strobe |
| base_i | input | 9 | First slot address to capture (1 to 509) |
| start_code_i | input | 8 | Start code a frame must carry |
| gang_i | input | 1 | Copy the first addressed slot to all channels |
| cfg_mode_i | input | 1 | Treat captures as in-band configuration frames |
| onoff_i | input | 4 | Per-channel on/off-only mask, bit i for channel i+1 |
| chan_o | output | 32 | Four channel bytes, channel 1 in bits 7:0 |
| new_o | output | 1 | One-cycle pulse: channels updated |
| seen_o | output | 1 | One-cycle pulse: first addressed slot received |
| cfg_we_o | output | 1 | One-cycle pulse: configuration bytes valid |
| cfg_o | output | 24 | Configuration bytes, channel-2 byte in bits 7:0 |

## Verification
Frames are sent at base addresses 1, 5, 2, 3 and 509, with distinct byte values per slot, so a wrong slot offset or a swapped channel shows up as a wrong byte in a specific lane. A wrong start code, a framing error mid-capture, a break mid-capture and stray bytes after a frame each test that exactly one frame's data, and never a mix, reaches the channels. Ganged, configuration (key present, key absent, and combined with ganged) and on/off-only frames with mid-range, 0x00 and 0xFF values separate the mode paths, while bases 0 and 510 with a full-length frame check that out-of-range addresses are never served.

// File: rtl/dmx_cap_pkg.sv
package dmx_cap_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,  // wait for break
    ST_SC,    // expect start code
    ST_SLOT,  // count slots up to base
    ST_CAP    // collect remaining channels
  } fr_state_e;
endpackage

// File: rtl/dmx_frame_fsm.sv
module dmx_frame_fsm
  import dmx_cap_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned SLOT_MAX = 512,
  parameter int unsigned CNT_W    = 16,
  localparam int unsigned ADDR_W  = $clog2(SLOT_MAX),
  localparam int unsigned IDX_W   = $clog2(NCH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  brk_i,
  input  logic                  byte_vld_i,
  input  logic [BYTE_W-1:0]     byte_i,
  input  logic                  frm_err_i,
  input  logic [ADDR_W-1:0]     base_i,
  input  logic [BYTE_W-1:0]     start_code_i,
  input  logic                  gang_i,
  output logic                  seen_o,
  output logic                  done_o,
  output logic [NCH*BYTE_W-1:0] set_o
);
  localparam int unsigned MAX_BASE = SLOT_MAX - NCH + 1;

  fr_state_e               state_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [IDX_W-1:0]        idx_q;
  logic [NCH-1:0][BYTE_W-1:0] set_q;
  logic                    seen_q, done_q;

  logic [CNT_W-1:0] cnt_nx;
  logic             base_ok, hit;

  assign cnt_nx  = cnt_q + 1'b1;
  assign base_ok = (base_i != '0) && (32'(base_i) <= MAX_BASE);
  assign hit     = base_ok && (cnt_nx == CNT_W'(base_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      set_q   <= '0;
      seen_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      seen_q <= 1'b0;
      done_q <= 1'b0;
      if (brk_i) begin
        state_q <= ST_SC;
        cnt_q   <= '0;
      end else if (byte_vld_i) begin
        unique case (state_q)
          ST_SC: begin
            cnt_q   <= '0;
            state_q <= (!frm_err_i && byte_i == start_code_i) ? ST_SLOT : ST_IDLE;
          end
          ST_SLOT: begin
            if (frm_err_i) begin
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_nx;
              if (hit) begin
                seen_q <= 1'b1;
                if (gang_i) begin
                  set_q   <= {NCH{byte_i}};
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
                end else begin
                  set_q[0] <= byte_i;
                  idx_q    <= IDX_W'(1);
                  state_q  <= ST_CAP;
                end
              end
            end
          end
          ST_CAP: begin
            if (frm_err_i) begin
              state_q <= ST_IDLE;
            end else begin
              set_q[idx_q] <= byte_i;
              if (idx_q == IDX_W'(NCH-1)) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign seen_o = seen_q;
  assign done_o = done_q;
  assign set_o  = set_q;
endmodule

// File: rtl/dmx_chan_hold.sv
module dmx_chan_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         onoff_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic         take;

  // on/off-only channels accept only the two extremes
  assign take = !onoff_i || (val_i == '0) || (val_i == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            q_q <= '0;
    else if (load_i && take) q_q <= val_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dmx_slot_capture.sv
module dmx_slot_capture
  import dmx_cap_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned SLOT_MAX = 512,
  parameter int unsigned CNT_W    = 16,
  parameter logic [7:0]  CFG_KEY  = 8'h81,
  localparam int unsigned ADDR_W  = $clog2(SLOT_MAX)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      brk_i,
  input  logic                      byte_vld_i,
  input  logic [BYTE_W-1:0]         byte_i,
  input  logic                      frm_err_i,
  input  logic [ADDR_W-1:0]         base_i,
  input  logic [BYTE_W-1:0]         start_code_i,
  input  logic                      gang_i,
  input  logic                      cfg_mode_i,
  input  logic [NCH-1:0]            onoff_i,
  output logic [NCH*BYTE_W-1:0]     chan_o,
  output logic                      new_o,
  output logic                      seen_o,
  output logic                      cfg_we_o,
  output logic [(NCH-1)*BYTE_W-1:0] cfg_o
);
  logic                  done;
  logic [NCH*BYTE_W-1:0] set;
  logic                  cfg_path, upd, cfg_hit;
  logic                  new_q, cfg_we_q;
  logic [(NCH-1)*BYTE_W-1:0] cfg_q;

  dmx_frame_fsm #(
    .NCH      (NCH),
    .SLOT_MAX (SLOT_MAX),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .brk_i        (brk_i),
    .byte_vld_i   (byte_vld_i),
    .byte_i       (byte_i),
    .frm_err_i    (frm_err_i),
    .base_i       (base_i),
    .start_code_i (start_code_i),
    .gang_i       (gang_i),
    .seen_o       (seen_o),
    .done_o       (done),
    .set_o        (set)
  );

  // ganged frames bypass the configuration key check
  assign cfg_path = cfg_mode_i && !gang_i;
  assign upd      = done && !cfg_path;
  assign cfg_hit  = done && cfg_path && (set[BYTE_W-1:0] == CFG_KEY);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dmx_chan_hold #(.W(BYTE_W)) u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (upd),
      .onoff_i (onoff_i[i]),
      .val_i   (set[i*BYTE_W +: BYTE_W]),
      .q_o     (chan_o[i*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      new_q    <= 1'b0;
      cfg_we_q <= 1'b0;
      cfg_q    <= '0;
    end else begin
      new_q    <= upd;
      cfg_we_q <= cfg_hit;
      if (cfg_hit) cfg_q <= set[NCH*BYTE_W-1:BYTE_W];
    end
  end

  assign new_o    = new_q;
  assign cfg_we_o = cfg_we_q;
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/dmx_slot_capture_chk.sv
module dmx_slot_capture_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           brk_i,
  input logic [8:0]     base_i,
  input logic           gang_i,
  input logic [NCH-1:0] onoff_i,
  input logic           seen_o,
  input logic           new_o,
  input logic           cfg_we_o,
  input logic [NCH*8-1:0] chan_o
);
  p_seen_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_o |=> !seen_o);

  p_cfg_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(new_o && cfg_we_o));

  p_chan_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !new_o |-> $stable(chan_o));

  p_onoff_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_o && $past(onoff_i[0])) |->
      (chan_o[7:0] == 8'h00 || chan_o[7:0] == 8'hFF || chan_o[7:0] == $past(chan_o[7:0])));

  p_gang_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_o && $past(gang_i) && $past(onoff_i) == '0) |->
      (chan_o[15:8] == chan_o[7:0] && chan_o[23:16] == chan_o[7:0] && chan_o[31:24] == chan_o[7:0]));

  p_bad_base_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_i == 9'd0 || base_i > 9'd509) |=> !seen_o);

  p_brk_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> !seen_o);
endmodule

bind dmx_slot_capture dmx_slot_capture_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .brk_i    (brk_i),
  .base_i   (base_i),
  .gang_i   (gang_i),
  .onoff_i  (onoff_i),
  .seen_o   (seen_o),
  .new_o    (new_o),
  .cfg_we_o (cfg_we_o),
  .chan_o   (chan_o)
);

// File: tb/dmx_slot_capture_tb.sv
module dmx_slot_capture_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        brk_i = 0, byte_vld_i = 0, frm_err_i = 0;
  logic [7:0]  byte_i = 0, start_code_i = 0;
  logic [8:0]  base_i = 9'd1;
  logic        gang_i = 0, cfg_mode_i = 0;
  logic [3:0]  onoff_i = 0;
  logic [31:0] chan_o;
  logic        new_o, seen_o, cfg_we_o;
  logic [23:0] cfg_o;

  always #5 clk_i = ~clk_i;

  dmx_slot_capture u_dut (.*);

  int    n_cmp = 0, n_bad = 0;
  string req = "R13";

  // reference model state
  int m_st = 0;  // 0 idle, 1 start code, 2 counting, 3 capturing
  int m_cnt = 0, m_idx = 0;
  int m_buf[4];
  bit m_pend = 0;
  int e_chan[4];
  int e_cfg[3];
  bit e_seen = 0, e_new = 0, e_cfg_we = 0;
  int dq[$];

  initial begin
    foreach (m_buf[i]) m_buf[i] = 0;
    foreach (e_chan[i]) e_chan[i] = 0;
    foreach (e_cfg[i]) e_cfg[i] = 0;
  end

  task automatic model_edge();
    e_new = 0; e_cfg_we = 0; e_seen = 0;
    if (m_pend) begin
      if (cfg_mode_i && !gang_i) begin
        if (m_buf[0] == 'h81) begin
          e_cfg_we = 1;
          for (int i = 0; i < 3; i++) e_cfg[i] = m_buf[i+1];
        end
      end else begin
        e_new = 1;
        for (int i = 0; i < 4; i++)
          if (!onoff_i[i] || m_buf[i] == 0 || m_buf[i] == 255) e_chan[i] = m_buf[i];
      end
    end
    m_pend = 0;
    if (brk_i) begin
      m_st = 1; m_cnt = 0;
    end else if (byte_vld_i) begin
      case (m_st)
        1: begin m_cnt = 0; m_st = (!frm_err_i && byte_i == start_code_i) ? 2 : 0; end
        2: if (frm_err_i) m_st = 0;
           else begin
             m_cnt++;
             if (base_i >= 1 && base_i <= 509 && m_cnt == int'(base_i)) begin
               e_seen = 1;
               if (gang_i) begin
                 for (int i = 0; i < 4; i++) m_buf[i] = byte_i;
                 m_pend = 1; m_st = 0;
               end else begin
                 m_buf[0] = byte_i; m_idx = 1; m_st = 3;
               end
             end
           end
        3: if (frm_err_i) m_st = 0;
           else begin
             m_buf[m_idx] = byte_i; m_idx++;
             if (m_idx == 4) begin m_pend = 1; m_st = 0; end
           end
        default: ;
      endcase
    end
  endtask

  task automatic cmp(string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    cmp("seen_o", seen_o, e_seen);
    cmp("new_o", new_o, e_new);
    cmp("cfg_we_o", cfg_we_o, e_cfg_we);
    cmp("chan_o", chan_o, {e_chan[3][7:0], e_chan[2][7:0], e_chan[1][7:0], e_chan[0][7:0]});
    cmp("cfg_o", cfg_o, {e_cfg[2][7:0], e_cfg[1][7:0], e_cfg[0][7:0]});
  endtask

  task automatic cyc(bit brk, bit vld, int b, bit err);
    brk_i = brk; byte_vld_i = vld; byte_i = b[7:0]; frm_err_i = err;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check_all();
  endtask

  task automatic send(int b);
    cyc(0, 1, b, 0);
    cyc(0, 0, 0, 0);
  endtask

  task automatic frame(int sc);
    cyc(1, 0, 0, 0);
    send(sc);
    foreach (dq[k]) send(dq[k]);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
  endtask

  task automatic fill(int n, int mul, int off);
    dq.delete();
    for (int k = 1; k <= n; k++) dq.push_back((k * mul + off) % 254 + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    req = "R13";
    check_all();
    rst_ni = 1'b1;
    cyc(0, 0, 0, 0);

    req = "R6 R9 base 1";
    dq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    frame(0);
    cmp("R6 ch order", chan_o, 32'h44332211);

    req = "R2 base 5";
    base_i = 9'd5;
    fill(12, 7, 3);
    frame(0);

    req = "R1 wrong start code";
    start_code_i = 8'h17;
    fill(10, 5, 40);
    frame(0);
    req = "R1 right start code";
    frame(8'h17);
    start_code_i = 8'h00;

    req = "R3 framing error";
    base_i = 9'd2;
    cyc(1, 0, 0, 0);
    send(0); send(9); send(10); send(11);
    cyc(0, 1, 12, 1);
    send(13); send(14); send(15);
    cyc(0, 0, 0, 0);
    req = "R3 error on start code";
    cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 1);
    send(1); send(2); send(3); send(4); send(5);

    req = "R12 stray bytes";
    dq = '{8'h21, 8'h31, 8'h41, 8'h51, 8'h61};
    frame(0);
    send(0); send(7); send(8); send(9); send(10); send(11);
    req = "R12 break with byte";
    cyc(1, 1, 8'h99, 0);
    send(0); send(3); send(4); send(5); send(6); send(7);

    req = "R11 break mid capture";
    cyc(1, 0, 0, 0);
    send(0); send(1); send(2); send(3);
    cyc(1, 0, 0, 0);
    send(0); send(70); send(71); send(72); send(73); send(74);
    cyc(0, 0, 0, 0);

    req = "R5 ganged";
    gang_i = 1; base_i = 9'd3;
    dq = '{8'h01, 8'h02, 8'h5A, 8'h04, 8'h05};
    frame(0);
    cmp("R5 all lanes", chan_o, 32'h5A5A5A5A);
    req = "R5 ganged with cfg mode";
    cfg_mode_i = 1;
    dq = '{8'h01, 8'h02, 8'h81, 8'h04};
    frame(0);
    gang_i = 0;

    req = "R7 config key";
    base_i = 9'd1;
    dq = '{8'h81, 8'hA1, 8'hB2, 8'hC3, 8'hD4};
    frame(0);
    cmp("R7 cfg bytes", cfg_o, 24'hC3B2A1);
    req = "R7 no key";
    dq = '{8'h80, 8'h01, 8'h02, 8'h03};
    frame(0);
    cfg_mode_i = 0;

    req = "R8 onoff";
    onoff_i = 4'b0101;
    dq = '{100, 0, 255, 77};
    frame(0);
    dq = '{255, 120, 0, 200};
    frame(0);
    dq = '{0, 9, 130, 255};
    frame(0);
    onoff_i = 4'b1111;
    dq = '{50, 60, 70, 80};
    frame(0);
    onoff_i = 4'b0000;

    req = "R10 base 0";
    base_i = 9'd0;
    fill(8, 3, 1);
    frame(0);
    req = "R10 base 510";
    base_i = 9'd510;
    fill(512, 1, 5);
    frame(0);
    req = "R10 base 509";
    base_i = 9'd509;
    frame(0);

    req = "R4 R9 idle";
    repeat (4) cyc(0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule